// File: doc/BRIEF.md
# Programmable Decimal Pulse Divider

This block divides a stream of input pulses by a decimal modulus N from 1 to 999. The modulus is set on three 4-bit BCD inputs: hundreds, tens and units. Input pulses arrive as one-cycle enables in the system-clock domain. The count is held in three decade down-counters chained by borrow, ordered units, then tens, then hundreds. When the chain reaches its final pulse, the block emits a one-cycle event and reloads all three digits from the inputs. The event also flips a toggle output. That output is a square feedback wave of period 2N, wide enough to drive a phase comparator.

A prescaler-enable input can place a decade prescaler ahead of the chain. The overall ratio then becomes 10N. The digit inputs are sampled only at a reload, so a new setting never disturbs a count already in progress. Out-of-range BCD codes are clamped to 9. An all-zero setting divides by one.

When reset is released, the block loads the digits in the first clock cycle. Pulses are counted from the second cycle on.

Top module: `bcd_pulse_divider`

## Requirements
- R1: While reset is held, and directly after it, `divEvent` and `fbOut` are both 0.
- R2: With the prescaler bypassed, exactly one `divEvent` occurs for every N accepted pulses. It is high for one clock, in the cycle after the clock edge that took the Nth pulse.
- R3: N equals 100·hundreds + 10·tens + units. Borrows ripple across every digit boundary, for example N = 213 and N = 100.
- R4: `fbOut` inverts at every clock edge that raises `divEvent` and holds its value at every other edge, giving period 2N.
- R5: With `prescaleEn` = 1 (prescaler phase cleared by reset), one `divEvent` occurs per 10·N pulses, and never in two consecutive cycles.
- R6: A digit code from 10 to 15 counts as 9, for example units = 12 selects N = 9 and tens = 10, units = 3 selects N = 93.
- R7: An all-zero setting (hundreds = tens = units = 0) gives N = 1, so every accepted pulse produces a `divEvent`.
- R8: A change on the digit inputs during a count does not alter the current period. The new N applies from the first period after the next reload.
- R9: Cycles with `pulseIn` = 0 do not advance the count and do not change `divEvent` or `fbOut`. A `divEvent` only follows a cycle with `pulseIn` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pulseIn | input | 1 | One-cycle enable, one per input pulse |
| prescaleEn | input | 1 | 1 = insert decade prescaler, 0 = bypass |
| digHund | input | 4 | Hundreds digit of N (BCD) |
| digTens | input | 4 | Tens digit of N (BCD) |
| digUnits | input | 4 | Units digit of N (BCD) |
| divEvent | output | 1 | One-cycle pulse at each terminal count |
| fbOut | output | 1 | Square feedback output, toggled by each event |

## Verification
A corrupted digit counter or a borrow lost between digits shows up only as a wrong interval between events. The bench therefore counts pulses between consecutive `divEvent`s rather than sampling once. A fault is seen at the latest one full period after it occurs. A reload that samples the digits at the wrong time shows in the first period after the digit change, so mid-count changes are followed across two events. A faulty toggle stage or prescaler shows on `fbOut` in the same cycle as the event, and as a tenfold error in the event interval.

// File: rtl/bcd_div_pkg.sv
package bcd_div_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

  typedef struct packed {
    logic load;  // parallel load of all digits
    logic step;  // decrement the units digit
  } divStrobe_t;
endpackage

// File: rtl/bcd_div_digit.sv
module bcd_div_digit
  import bcd_div_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               load,
  input  logic [DIGIT_W-1:0] loadVal,
  input  logic               borrowIn,
  output logic [DIGIT_W-1:0] value,
  output logic               borrowOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      value <= '0;
    else if (load)
      value <= loadVal;
    else if (borrowIn)
      value <= (value == '0) ? DIGIT_MAX : value - 1'b1;
  end

  // A digit passing from 0 to 9 lends a borrow to its upper neighbour.
  assign borrowOut = borrowIn & (value == '0);
endmodule

// File: rtl/bcd_div_datapath.sv
module bcd_div_datapath
  import bcd_div_pkg::*;
#(
  parameter int NUM_DIGITS = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  divStrobe_t                        ctl,
  input  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digitsIn,
  output logic                              atOne,
  output logic                              chainWrap
);
  localparam int CNT_W = NUM_DIGITS * DIGIT_W;

  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] clampVal;
  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] loadVal;
  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] curVal;
  logic [NUM_DIGITS:0]                borrow;
  logic                               allZero;

  assign borrow[0] = ctl.step;
  assign allZero   = (clampVal == '0);

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    assign clampVal[i] = (digitsIn[i] > DIGIT_MAX) ? DIGIT_MAX : digitsIn[i];

    if (i == 0) begin : g_units
      // A zero modulus is promoted to one.
      assign loadVal[i] = allZero ? DIGIT_W'(1) : clampVal[i];
    end else begin : g_upper
      assign loadVal[i] = clampVal[i];
    end

    bcd_div_digit u_digit (
      .clk      (clk),
      .rstN     (rstN),
      .load     (ctl.load),
      .loadVal  (loadVal[i]),
      .borrowIn (borrow[i]),
      .value    (curVal[i]),
      .borrowOut(borrow[i+1])
    );
  end

  assign atOne     = (curVal == CNT_W'(1));
  assign chainWrap = borrow[NUM_DIGITS];
endmodule

// File: rtl/bcd_div_ctrl.sv
module bcd_div_ctrl
  import bcd_div_pkg::*;
#(
  parameter int PRE_MOD = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pulseIn,
  input  logic       prescaleEn,
  input  logic       atOne,
  input  logic       chainWrap,
  output divStrobe_t ctl,
  output logic       divEvent,
  output logic       fbOut
);
  localparam int PRE_W = (PRE_MOD > 1) ? $clog2(PRE_MOD) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_MOD - 1);

  logic [PRE_W-1:0] preCnt;
  logic             primed;
  logic             preTick;
  logic             cntEn;
  logic             hit;

  assign preTick  = !prescaleEn || (preCnt == PRE_LAST);
  assign cntEn    = pulseIn && preTick && primed;
  assign hit      = cntEn && atOne;
  assign ctl.load = !primed || hit || chainWrap;
  assign ctl.step = cntEn && !atOne;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      preCnt <= '0;
    else if (!prescaleEn)
      preCnt <= '0;
    else if (pulseIn)
      preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed   <= 1'b0;
      divEvent <= 1'b0;
      fbOut    <= 1'b0;
    end else begin
      primed   <= 1'b1;
      divEvent <= hit;
      fbOut    <= fbOut ^ hit;
    end
  end
endmodule

// File: rtl/bcd_pulse_divider.sv
module bcd_pulse_divider
  import bcd_div_pkg::*;
#(
  parameter int PRE_MOD = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pulseIn,
  input  logic       prescaleEn,
  input  logic [3:0] digHund,
  input  logic [3:0] digTens,
  input  logic [3:0] digUnits,
  output logic       divEvent,
  output logic       fbOut
);
  localparam int NUM_DIGITS = 3;

  divStrobe_t                         ctl;
  logic                               atOne;
  logic                               chainWrap;
  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digitsIn;

  assign digitsIn = {digHund, digTens, digUnits};

  bcd_div_ctrl #(.PRE_MOD(PRE_MOD)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pulseIn   (pulseIn),
    .prescaleEn(prescaleEn),
    .atOne     (atOne),
    .chainWrap (chainWrap),
    .ctl       (ctl),
    .divEvent  (divEvent),
    .fbOut     (fbOut)
  );

  bcd_div_datapath #(.NUM_DIGITS(NUM_DIGITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .digitsIn (digitsIn),
    .atOne    (atOne),
    .chainWrap(chainWrap)
  );
endmodule

// File: rtl/bcd_div_checker.sv
module bcd_div_checker (
  input logic clk,
  input logic rstN,
  input logic pulseIn,
  input logic prescaleEn,
  input logic divEvent,
  input logic fbOut
);
  p_fb_flips_r4: assert property (@(posedge clk) disable iff (!rstN)
    divEvent |-> (fbOut != $past(fbOut)));

  p_fb_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    !divEvent |-> $stable(fbOut));

  p_event_after_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    divEvent |-> $past(pulseIn));

  p_prescale_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (divEvent && prescaleEn) |=> !divEvent);
endmodule

bind bcd_pulse_divider bcd_div_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pulseIn   (pulseIn),
  .prescaleEn(prescaleEn),
  .divEvent  (divEvent),
  .fbOut     (fbOut)
);

// File: tb/tb_bcd_pulse_divider.sv
module tb_bcd_pulse_divider;
  localparam time CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pulseIn = 1'b0;
  logic       prescaleEn = 1'b0;
  logic [3:0] digHund = 4'd0;
  logic [3:0] digTens = 4'd0;
  logic [3:0] digUnits = 4'd0;
  logic       divEvent;
  logic       fbOut;

  int   nChecks = 0;
  int   nFails = 0;
  logic evtSeen;
  logic fbSeen;

  bcd_pulse_divider dut (
    .clk       (clk),
    .rstN      (rstN),
    .pulseIn   (pulseIn),
    .prescaleEn(prescaleEn),
    .digHund   (digHund),
    .digTens   (digTens),
    .digUnits  (digUnits),
    .divEvent  (divEvent),
    .fbOut     (fbOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setDigits(input int h, input int t, input int u);
    digHund = 4'(h);
    digTens = 4'(t);
    digUnits = 4'(u);
  endtask

  task automatic doReset();
    pulseIn = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // One pulse, then sample the outputs one edge later.
  task automatic sendPulse();
    @(negedge clk);
    pulseIn = 1'b1;
    @(negedge clk);
    pulseIn = 1'b0;
    evtSeen = divEvent;
    fbSeen = fbOut;
  endtask

  task automatic countToEvent(output int cnt);
    cnt = 0;
    do begin
      sendPulse();
      cnt++;
    end while (!evtSeen && cnt < 20000);
  endtask

  task automatic testReset();
    int c;
    setDigits(2, 1, 3);
    prescaleEn = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 divEvent in reset", divEvent, 0);
    check("R1 fbOut in reset", fbOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 divEvent after reset", divEvent, 0);
    check("R1 fbOut after reset", fbOut, 0);
    c = 0;
  endtask

  task automatic testBasic();
    int c;
    countToEvent(c);
    check("R3 period 213", c, 213);
    check("R4 fbOut after 1st event", fbSeen, 1);
    @(negedge clk);
    check("R2 event one cycle wide", divEvent, 0);
    countToEvent(c);
    check("R2 second period 213", c, 213);
    check("R4 fbOut after 2nd event", fbSeen, 0);
  endtask

  task automatic testReloadTiming();
    int c;
    repeat (50) sendPulse();
    setDigits(0, 0, 5);
    countToEvent(c);
    check("R8 old modulus finishes", c, 163);
    countToEvent(c);
    check("R8 new modulus applies", c, 5);
  endtask

  task automatic testHundred();
    int c;
    setDigits(1, 0, 0);
    countToEvent(c);
    check("R8 period before reload", c, 5);
    countToEvent(c);
    check("R3 period 100", c, 100);
  endtask

  task automatic testClamp();
    int c;
    setDigits(0, 0, 12);
    countToEvent(c);
    check("R8 period 100 kept", c, 100);
    countToEvent(c);
    check("R6 units 12 -> 9", c, 9);
    setDigits(0, 10, 3);
    countToEvent(c);
    check("R6 period 9 kept", c, 9);
    countToEvent(c);
    check("R6 tens 10 -> 93", c, 93);
  endtask

  task automatic testZero();
    int c;
    setDigits(0, 0, 0);
    countToEvent(c);
    check("R7 period 93 kept", c, 93);
    countToEvent(c);
    check("R7 zero -> 1 first", c, 1);
    countToEvent(c);
    check("R7 zero -> 1 second", c, 1);
  endtask

  task automatic testIdle();
    int c;
    int bad;
    setDigits(0, 0, 5);
    doReset();
    sendPulse();
    sendPulse();
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (divEvent !== 1'b0 || fbOut !== 1'b0) bad++;
    end
    check("R9 idle cycles quiet", bad, 0);
    countToEvent(c);
    check("R9 count kept across idle", c, 3);
  endtask

  task automatic testPrescale();
    int c;
    setDigits(0, 0, 7);
    prescaleEn = 1'b1;
    doReset();
    countToEvent(c);
    check("R5 prescaled period", c, 70);
    check("R5 fbOut toggled", fbSeen, 1);
    countToEvent(c);
    check("R5 prescaled second period", c, 70);
    prescaleEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    testReset();
    testBasic();
    testReloadTiming();
    testHundred();
    testClamp();
    testZero();
    testIdle();
    testPrescale();
    finishRun();
  end
endmodule